// File: doc/BRIEF.md
# Lane Shuffle Crossbar

This block steers one word per lane between the register banks of a multi-lane vector/matrix datapath and the operand inputs of the per-lane functional units. Element-wise work needs no cross-lane traffic. Reductions (dot products, vector-matrix and matrix-matrix products) and expansions (outer products) do need it, and this crossbar provides it. Any lane's word can reach any lane's output.

Each accepted beat carries one word per lane, a 2-bit operation code and a lane index. The block supports three operations. Pass leaves each word in its own lane. Rotate shifts the words cyclically across the lanes by the index. Broadcast copies the lane named by the index to every lane. The result is registered and appears one cycle later, together with a valid flag. The lane count is a parameter; the supported values are 1, 4 and 8, and the words are 32 bits wide.

Top module: `lane_shuffle_xbar`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears `out_valid` and every bit of `out_words` to zero at that edge. The reset is synchronous.
- R2: Operation code 2'b00 (pass) makes output lane i equal to input lane i, for every lane. Lane i occupies bits [32i+31:32i] of both word buses.
- R3: Operation code 2'b01 (rotate) makes output lane i equal to input lane (i + k) mod LANES, where k is `in_idx`. A rotate by k = LANES-1 wraps around to the low lanes.
- R4: Operation code 2'b10 (broadcast) makes every output lane equal to input lane k, where k is `in_idx`.
- R5: Operation code 2'b11 is reserved and behaves exactly like pass.
- R6: A beat accepted at a rising edge with `in_valid` high has its result on `out_words`, with `out_valid` high, right after that edge. This gives one cycle of latency. Beats on consecutive cycles produce results on consecutive cycles.
- R7: After a rising edge with `in_valid` low, `out_valid` is low and `out_words` keeps its previous value, whatever the other inputs are.
- R8: In pass mode and reserved mode, the value of `in_idx` has no effect on the result.
- R9: When LANES is 1, every operation code returns the single input word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The beat on the other inputs is to be captured |
| in_op | input | 2 | Operation: 00 pass, 01 rotate, 10 broadcast, 11 reserved (pass) |
| in_idx | input | max(1, log2 LANES) | Rotate amount or broadcast source lane |
| in_words | input | LANES*WORD_W | Input words, lane i at bits [WORD_W*i +: WORD_W] |
| out_valid | output | 1 | `out_words` holds the result of the beat captured at the last edge |
| out_words | output | LANES*WORD_W | Steered words, lane i at bits [WORD_W*i +: WORD_W] |

## Verification
Every result is due exactly one rising edge after the edge that captured its beat. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, which is half a period after the capturing edge. This holds for back-to-back beats, for the idle cycle that must leave the data unchanged, and for the reset clear. The same single-edge spacing is written into the bound checker as `|=>` properties: each one compares a lane against the lane selected from the previous cycle's input.

// File: rtl/xbar_pkg.sv
// Package: shared operation encoding and width helper for the lane shuffle crossbar.
// Assumes: lane counts are powers of two (1, 4, 8 are the supported set).
package xbar_pkg;

    typedef enum logic [1:0] {
        XB_PASS  = 2'b00,
        XB_ROT   = 2'b01,
        XB_BCAST = 2'b10,
        XB_RSVD  = 2'b11
    } xb_op_e;

    // Width of the lane index; one bit minimum so ports never collapse to zero width.
    function automatic int unsigned idx_width(input int unsigned lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

endpackage

// File: rtl/xbar_route_ctrl.sv
// Module: turns the operation code and lane index into one source-lane number per output lane.
// Assumes: in_idx < LANES; with a single lane every source is lane 0.
module xbar_route_ctrl
    import xbar_pkg::*;
#(
    parameter int unsigned LANES = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [1:0]             op,
    input  logic [IDX_W-1:0]       idx,
    output logic [LANES*IDX_W-1:0] src_sel
);

    localparam logic [IDX_W:0] LANE_COUNT = (IDX_W+1)'(LANES);

    generate
        if (LANES == 1) begin : g_single
            // A single lane has nowhere else to route from.
            assign src_sel = '0;
        end else begin : g_multi
            for (genvar g = 0; g < LANES; g++) begin : g_lane
                localparam logic [IDX_W:0] LANE_ID = (IDX_W+1)'(g);
                logic [IDX_W:0] sum_raw;
                logic [IDX_W:0] sum_wrap;

                // Rotation source before and after the modulo wrap.
                assign sum_raw  = LANE_ID + {1'b0, idx};
                assign sum_wrap = (sum_raw >= LANE_COUNT) ? (sum_raw - LANE_COUNT) : sum_raw;

                // Pick this output lane's source according to the operation.
                always_comb begin
                    case (xb_op_e'(op))
                        XB_ROT:   src_sel[g*IDX_W +: IDX_W] = sum_wrap[IDX_W-1:0];
                        XB_BCAST: src_sel[g*IDX_W +: IDX_W] = idx;
                        default:  src_sel[g*IDX_W +: IDX_W] = LANE_ID[IDX_W-1:0];
                    endcase
                end
            end
        end
    endgenerate

endmodule

// File: rtl/xbar_lane_mux.sv
// Module: one crossbar column, a LANES-to-1 word selector for a single output lane.
// Assumes: sel is below LANES; an out-of-range select falls back to lane 0.
module xbar_lane_mux #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned IDX_W  = 3
) (
    input  logic [LANES*WORD_W-1:0] words,
    input  logic [IDX_W-1:0]        sel,
    output logic [WORD_W-1:0]       word
);

    // Flat compare-and-select over every source lane.
    always_comb begin
        word = words[0 +: WORD_W];
        for (int s = 0; s < LANES; s++) begin
            if (sel == IDX_W'(s)) begin
                word = words[s*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/xbar_out_stage.sv
// Module: output register with a travelling valid bit; data loads only on a valid beat.
// Assumes: synchronous active-low reset clears both data and valid.
module xbar_out_stage #(
    parameter int unsigned BUS_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] d,
    output logic             q_valid,
    output logic [BUS_W-1:0] q
);

    // Valid follows the load strobe each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= load;
    end

    // Data is captured on a load and held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/lane_shuffle_xbar.sv
// Module: registered full crossbar across LANES lanes, doing pass, lane rotate and broadcast.
// Assumes: one word per lane, in_idx < LANES, and one cycle from capture to output.
module lane_shuffle_xbar
    import xbar_pkg::*;
#(
    parameter int unsigned LANES  = 8,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned IDX_W = xbar_pkg::idx_width(LANES),
    localparam int unsigned BUS_W = LANES * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [BUS_W-1:0] in_words,
    output logic             out_valid,
    output logic [BUS_W-1:0] out_words
);

    logic [LANES*IDX_W-1:0] src_sel;
    logic [BUS_W-1:0]       steered;

    xbar_route_ctrl #(
        .LANES (LANES),
        .IDX_W (IDX_W)
    ) u_route (
        .op      (in_op),
        .idx     (in_idx),
        .src_sel (src_sel)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_col
            xbar_lane_mux #(
                .LANES  (LANES),
                .WORD_W (WORD_W),
                .IDX_W  (IDX_W)
            ) u_mux (
                .words (in_words),
                .sel   (src_sel[l*IDX_W +: IDX_W]),
                .word  (steered[l*WORD_W +: WORD_W])
            );
        end
    endgenerate

    xbar_out_stage #(
        .BUS_W (BUS_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .d       (steered),
        .q_valid (out_valid),
        .q       (out_words)
    );

endmodule

// File: rtl/xbar_checker.sv
// Module: timing and routing properties for lane_shuffle_xbar, attached by bind below.
// Assumes: the same LANES/WORD_W as the bound instance; every check spans one edge.
module xbar_checker #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned IDX_W = xbar_pkg::idx_width(LANES),
    localparam int unsigned BUS_W = LANES * WORD_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       in_op,
    input logic [IDX_W-1:0] in_idx,
    input logic [BUS_W-1:0] in_words,
    input logic             out_valid,
    input logic [BUS_W-1:0] out_words
);

    function automatic logic [WORD_W-1:0] pick(input logic [BUS_W-1:0] b, input int unsigned k);
        return b[k*WORD_W +: WORD_W];
    endfunction

    // R1: a reset edge leaves nothing valid and clears the data.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_words == '0));

    // R6: a captured beat is flagged valid one edge later.
    a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid) |=> out_valid);

    // R7: an idle edge drops valid and holds the data.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !in_valid) |=> (!out_valid && $stable(out_words)));

    // R2: pass keeps every lane in place.
    a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid && in_op == 2'b00) |=> out_words == $past(in_words));

    // R5: the reserved code behaves like pass.
    a_r5_reserved_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid && in_op == 2'b11) |=> out_words == $past(in_words));

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane_chk
            // R3: output lane j takes input lane (j + k) mod LANES.
            a_r3_rotate_lane: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && in_valid && in_op == 2'b01) |=>
                out_words[j*WORD_W +: WORD_W] ==
                    $past(pick(in_words, (j + int'(in_idx)) % LANES)));

            // R4: every output lane takes input lane k.
            a_r4_broadcast_lane: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && in_valid && in_op == 2'b10) |=>
                out_words[j*WORD_W +: WORD_W] ==
                    $past(pick(in_words, int'(in_idx) % LANES)));
        end
    endgenerate

endmodule

bind lane_shuffle_xbar xbar_checker #(
    .LANES  (LANES),
    .WORD_W (WORD_W)
) u_xbar_chk (.*);

// File: tb/lane_shuffle_xbar_test.sv
// Bench: a vector table walked back-to-back, then directed reset, hold and single-lane checks.
module lane_shuffle_xbar_test;

    localparam int CLK_PERIOD = 10;
    localparam int L  = 8;
    localparam int W  = 32;
    localparam int IW = 3;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  idx;
        logic [31:0] seed;
        logic [2:0]  src0;   // expected source lane of output lane 0
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 3'd0, 32'hA000_0000, 3'd0},   // R2 pass
        '{2'b00, 3'd5, 32'hA100_0010, 3'd0},   // R8 pass, index ignored
        '{2'b01, 3'd1, 32'hB000_0000, 3'd1},   // R3 rotate by 1
        '{2'b01, 3'd3, 32'hB100_0300, 3'd3},   // R3 rotate by 3
        '{2'b01, 3'd7, 32'hB200_7000, 3'd7},   // R3 rotate by LANES-1, wrap
        '{2'b01, 3'd0, 32'hB300_0001, 3'd0},   // R3 rotate by 0
        '{2'b10, 3'd0, 32'hC000_0000, 3'd0},   // R4 broadcast lane 0
        '{2'b10, 3'd6, 32'hC100_0600, 3'd6},   // R4 broadcast lane 6
        '{2'b10, 3'd7, 32'hC200_0700, 3'd7},   // R4 broadcast top lane
        '{2'b11, 3'd4, 32'hD000_0400, 3'd0},   // R5 reserved acts as pass, R8
        '{2'b11, 3'd0, 32'hD100_0000, 3'd0}    // R5 reserved, index zero
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [1:0]      in_op = 2'b00;
    logic [IW-1:0]   in_idx = '0;
    logic [L*W-1:0]  in_words = '0;
    logic            out_valid;
    logic [L*W-1:0]  out_words;

    logic            one_valid = 1'b0;
    logic [1:0]      one_op = 2'b00;
    logic [0:0]      one_idx = 1'b0;
    logic [W-1:0]    one_words = '0;
    logic            one_out_valid;
    logic [W-1:0]    one_out_words;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_shuffle_xbar #(.LANES(L), .WORD_W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_idx    (in_idx),
        .in_words  (in_words),
        .out_valid (out_valid),
        .out_words (out_words)
    );

    lane_shuffle_xbar #(.LANES(1), .WORD_W(W)) uut_one (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (one_valid),
        .in_op     (one_op),
        .in_idx    (one_idx),
        .in_words  (one_words),
        .out_valid (one_out_valid),
        .out_words (one_out_words)
    );

    function automatic logic [W-1:0] lane_word(input logic [31:0] seed, input int i);
        return seed + 32'(i) * 32'h0101_1011;
    endfunction

    function automatic logic [L*W-1:0] make_bus(input logic [31:0] seed);
        logic [L*W-1:0] b;
        for (int i = 0; i < L; i++) b[i*W +: W] = lane_word(seed, i);
        return b;
    endfunction

    // Reference source lane per requirement R2..R5.
    function automatic int ref_src(input logic [1:0] op, input int idx, input int lane);
        case (op)
            2'b01:   return (lane + idx) % L;
            2'b10:   return idx;
            default: return lane;
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] op, input int idx);
        case (op)
            2'b01:   return "R3";
            2'b10:   return "R4";
            2'b11:   return "R5";
            default: return (idx != 0) ? "R8" : "R2";
        endcase
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic [L*W-1:0] held;

        // R1: reset state after edges with rst_n low.
        repeat (2) @(negedge clk);
        chk("R1", {31'd0, out_valid}, 32'd0);
        for (int i = 0; i < L; i++) chk("R1", out_words[i*W +: W], 32'd0);
        rst_n = 1'b1;

        // Table walk, one beat per cycle; R6 back-to-back latency.
        @(negedge clk);
        for (int v = 0; v < NVEC; v++) begin
            in_valid = 1'b1;
            in_op    = VECS[v].op;
            in_idx   = VECS[v].idx;
            in_words = make_bus(VECS[v].seed);
            @(negedge clk);
            chk("R6", {31'd0, out_valid}, 32'd1);
            chk(req_of(VECS[v].op, int'(VECS[v].idx)), out_words[0 +: W],
                lane_word(VECS[v].seed, int'(VECS[v].src0)));
            for (int i = 1; i < L; i++) begin
                chk(req_of(VECS[v].op, int'(VECS[v].idx)), out_words[i*W +: W],
                    lane_word(VECS[v].seed, ref_src(VECS[v].op, int'(VECS[v].idx), i)));
            end
        end

        // R7: idle cycles drop valid and hold the last result despite new inputs.
        held     = out_words;
        in_valid = 1'b0;
        in_op    = 2'b10;
        in_idx   = 3'd2;
        in_words = make_bus(32'hEEEE_0000);
        for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            chk("R7", {31'd0, out_valid}, 32'd0);
            for (int i = 0; i < L; i++) chk("R7", out_words[i*W +: W], held[i*W +: W]);
        end

        // R6: valid returns on the next beat, rotate result one edge later.
        in_valid = 1'b1;
        in_op    = 2'b01;
        in_idx   = 3'd6;
        in_words = make_bus(32'h1234_5678);
        @(negedge clk);
        chk("R6", {31'd0, out_valid}, 32'd1);
        for (int i = 0; i < L; i++)
            chk("R3", out_words[i*W +: W], lane_word(32'h1234_5678, (i + 6) % L));

        // R1: a mid-run reset clears a live result.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", {31'd0, out_valid}, 32'd0);
        for (int i = 0; i < L; i++) chk("R1", out_words[i*W +: W], 32'd0);
        rst_n    = 1'b1;
        in_valid = 1'b0;

        // R9: single-lane build returns its word for every operation code and index.
        for (int o = 0; o < 4; o++) begin
            one_valid = 1'b1;
            one_op    = 2'(o);
            one_idx   = 1'(o);
            one_words = 32'h5A5A_0000 + 32'(o);
            @(negedge clk);
            chk("R9", {31'd0, one_out_valid}, 32'd1);
            chk("R9", one_out_words, 32'h5A5A_0000 + 32'(o));
        end
        one_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule